// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer with Early Warning

This block is a watchdog timer driven by a slow tick enable of about 32 kHz. Software programs a timeout and an operating mode over a simple 32-bit register bus. It must then keep writing a restart code before the timeout runs out. If it stops doing so, the block issues a system reset pulse. It can also drive an external reset pin whose active level is programmable. Every write must carry a key, either a code in a fixed field of the data word or an exact magic value. A write with a wrong key leaves the block untouched.

In early-warning mode the countdown has two phases. The first expiry raises a level interrupt and reloads the counter. A second expiry with no restart in between fires the reset. Software normally programs half of the total timeout, so the interrupt comes at half time and the reset at full time. The block also has an immediate software reset command and a bank of individually held software reset lines.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, irq, sys_rst and sw_rst are all zero. ext_rst_pin sits at its inactive level, which is high because polarity bit 1 resets to 0. The mode, length and reset-bank registers read as zero.
- R2: A write to offset 0x00 updates the mode register only when data[31:24] is 0x22. The mode fields are: bit 0 run, bit 1 pin active high, bit 2 pin enable, bit 3 interrupt enable, bit 4 auto-restart, bit 6 two-phase, bit 8 route to the reset bank. A read returns these fields with bits 31:24 as zero.
- R3: A write to offset 0x04 updates the length only when data[4:0] is 0x08. The length sits in data[LEN_W+4:5] and reads back in the same place, with bits 4:0 as zero.
- R4: When run rises through a keyed write, a single-phase countdown starts. sys_rst then rises exactly length × 2^UNIT_LOG2 ticks later.
- R5: Writing exactly 0x1971 to offset 0x08 reloads the count from the length and clears irq. Any other value there has no effect.
- R6: With two-phase and interrupt enable both set, the first expiry raises irq and reloads the count, and the second expiry raises sys_rst. With two-phase set but interrupt enable clear, the block behaves as single-phase.
- R7: A keyed mode write that clears run stops the countdown and clears irq one cycle later.
- R8: Writing exactly 0x1209 to offset 0x14 starts a reset pulse at once, whether or not run is set. Any other value has no effect.
- R9: A reset pulse holds sys_rst high for PULSE_TICKS ticks. During the pulse, ext_rst_pin is at the bit-1 level if pin enable is set, and at the inactive level otherwise. When the pulse ends, run clears and irq clears.
- R10: A write to offset 0x18 sets sw_rst to data[SW_N-1:0] only when data[31:24] is 0x88. Each line holds until it is rewritten, and the lines read back at the same offset.
- R11: Mode bit 15 reads 1 after a pulse caused by expiry. It reads 0 after a pulse caused by the 0x14 command.
- R12: With auto-restart set, run survives the pulse and the countdown restarts from the length when the pulse ends.
- R13: With route set, every sw_rst line is asserted during an expiry pulse and returns to its stored value afterwards.
- R14: The countdown and the pulse advance only in cycles where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle per slow tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data including key |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Early-warning interrupt level |
| sys_rst | output | 1 | System reset pulse |
| ext_rst_pin | output | 1 | External reset pin, polarity programmable |
| sw_rst | output | SW_N | Held software reset lines |

## Verification
The assertions assume that a write strobe lasts one cycle with address and data stable during it. They also assume that bus_addr is always a defined value, because the key comparisons decode it directly. The stimulus always raises bus_wr for exactly one cycle at a falling edge. It changes bus_addr only between checks. It keeps tick high except in the gating test, so every expected edge can be counted from the write that started the countdown.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
   localparam logic [7:0]  OFS_MODE = 8'h00;
   localparam logic [7:0]  OFS_LEN  = 8'h04;
   localparam logic [7:0]  OFS_KICK = 8'h08;
   localparam logic [7:0]  OFS_NOW  = 8'h14;
   localparam logic [7:0]  OFS_BANK = 8'h18;
   localparam logic [7:0]  KEY_MODE = 8'h22;
   localparam logic [7:0]  KEY_BANK = 8'h88;
   localparam logic [4:0]  KEY_LEN  = 5'h08;
   localparam logic [31:0] KICK_CODE = 32'h0000_1971;
   localparam logic [31:0] NOW_CODE  = 32'h0000_1209;
   localparam int MB_RUN   = 0;
   localparam int MB_POL   = 1;
   localparam int MB_PIN   = 2;
   localparam int MB_IRQ   = 3;
   localparam int MB_AUTO  = 4;
   localparam int MB_DUAL  = 6;
   localparam int MB_ROUTE = 8;
   localparam int MB_CAUSE = 15;

   typedef struct packed {
      logic route;
      logic dual;
      logic auto_go;
      logic irq_en;
      logic pin_en;
      logic pol_hi;
      logic run;
   } mode_t;
endpackage

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
   import keyed_wdt_pkg::*;
#(
   parameter int LEN_W = 11,
   parameter int SW_N  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [7:0]        addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              exp_start,
   input  logic              now_start,
   input  logic              pulse_done,
   output mode_t             mode,
   output logic [LEN_W-1:0]  len,
   output logic [SW_N-1:0]   bank,
   output logic              kick,
   output logic              now_hit,
   output logic              run_rise
);
   localparam int LEN_TOP = LEN_W + 4;

   if (LEN_TOP > 31) begin : g_bad_len
      $error("keyed_wdt_regs: length field does not fit the word");
   end
   if (SW_N < 1 || SW_N > 24) begin : g_bad_bank
      $error("keyed_wdt_regs: reset bank must fit below the key field");
   end

   logic mode_ok, len_ok, bank_ok, cause;

   assign mode_ok  = wr && addr == OFS_MODE && wdata[31:24] == KEY_MODE;
   assign len_ok   = wr && addr == OFS_LEN  && wdata[4:0]   == KEY_LEN;
   assign bank_ok  = wr && addr == OFS_BANK && wdata[31:24] == KEY_BANK;
   assign kick     = wr && addr == OFS_KICK && wdata == KICK_CODE;
   assign now_hit  = wr && addr == OFS_NOW  && wdata == NOW_CODE;
   assign run_rise = mode_ok && wdata[MB_RUN] && !mode.run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= '0;
         len   <= '0;
         bank  <= '0;
         cause <= 1'b0;
      end else begin
         if (mode_ok) begin
            mode.run     <= wdata[MB_RUN];
            mode.pol_hi  <= wdata[MB_POL];
            mode.pin_en  <= wdata[MB_PIN];
            mode.irq_en  <= wdata[MB_IRQ];
            mode.auto_go <= wdata[MB_AUTO];
            mode.dual    <= wdata[MB_DUAL];
            mode.route   <= wdata[MB_ROUTE];
         end else if (pulse_done && !mode.auto_go) begin
            mode.run <= 1'b0;
         end
         if (len_ok)
            len <= wdata[LEN_TOP:5];
         if (bank_ok)
            bank <= wdata[SW_N-1:0];
         if (exp_start)
            cause <= 1'b1;
         else if (now_start)
            cause <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_MODE: begin
            rdata[MB_RUN]   = mode.run;
            rdata[MB_POL]   = mode.pol_hi;
            rdata[MB_PIN]   = mode.pin_en;
            rdata[MB_IRQ]   = mode.irq_en;
            rdata[MB_AUTO]  = mode.auto_go;
            rdata[MB_DUAL]  = mode.dual;
            rdata[MB_ROUTE] = mode.route;
            rdata[MB_CAUSE] = cause;
         end
         OFS_LEN:  rdata[LEN_TOP:5]  = len;
         OFS_BANK: rdata[SW_N-1:0]   = bank;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/keyed_wdt_count.sv
module keyed_wdt_count #(
   parameter int LEN_W     = 11,
   parameter int UNIT_LOG2 = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             two_phase,
   input  logic             hold,
   input  logic             reload,
   input  logic [LEN_W-1:0] len,
   output logic             irq,
   output logic             fire
);
   localparam int CW = LEN_W + UNIT_LOG2;

   if (UNIT_LOG2 < 0) begin : g_bad_unit
      $error("keyed_wdt_count: unit exponent must not be negative");
   end

   logic [CW-1:0] remain, load;
   logic          phase, last, step;

   if (UNIT_LOG2 == 0) begin : g_raw
      assign load = len;
   end else begin : g_scaled
      assign load = {len, {UNIT_LOG2{1'b0}}};
   end

   assign step = run && tick && !hold && !reload;
   assign last = remain <= CW'(1);
   assign fire = step && last && !(two_phase && !phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         phase  <= 1'b0;
         irq    <= 1'b0;
      end else if (reload) begin
         remain <= load;
         phase  <= 1'b0;
         irq    <= 1'b0;
      end else if (!run) begin
         phase <= 1'b0;
         irq   <= 1'b0;
      end else if (step) begin
         if (last) begin
            remain <= load;
            if (two_phase && !phase) begin
               phase <= 1'b1;
               irq   <= 1'b1;
            end
         end else begin
            remain <= remain - CW'(1);
         end
      end
   end
endmodule

// File: rtl/keyed_wdt_pulse.sv
module keyed_wdt_pulse #(
   parameter int PULSE_TICKS = 16,
   parameter int SW_N        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            start,
   input  logic            pin_en,
   input  logic            pol_hi,
   input  logic            route,
   input  logic [SW_N-1:0] bank,
   output logic            active,
   output logic            done,
   output logic            pin,
   output logic [SW_N-1:0] lines
);
   localparam int PW = $clog2(PULSE_TICKS + 1);

   if (PULSE_TICKS < 1) begin : g_bad_pulse
      $error("keyed_wdt_pulse: pulse must last at least one tick");
   end

   logic [PW-1:0] cnt;

   assign done = active && tick && cnt <= PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start && !active) begin
         active <= 1'b1;
         cnt    <= PW'(PULSE_TICKS);
      end else if (done) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (active && tick) begin
         cnt <= cnt - PW'(1);
      end
   end

   assign pin = (active && pin_en) ? pol_hi : !pol_hi;

   for (genvar i = 0; i < SW_N; i++) begin : g_line
      assign lines[i] = bank[i] | (route & active);
   end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import keyed_wdt_pkg::*;
#(
   parameter int LEN_W         = 11,
   parameter int UNIT_LOG2     = 9,
   parameter int PULSE_TICKS   = 16,
   parameter int SW_N          = 8,
   parameter int MAX_SECONDS   = 31,
   parameter int UNITS_PER_SEC = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            bus_wr,
   input  logic [7:0]      bus_addr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic            irq,
   output logic            sys_rst,
   output logic            ext_rst_pin,
   output logic [SW_N-1:0] sw_rst
);
   localparam int LONGEST = MAX_SECONDS * UNITS_PER_SEC;

   if (LONGEST >= (1 << LEN_W)) begin : g_bad_range
      $error("keyed_wdt: LEN_W too narrow for the longest timeout");
   end

   mode_t            mode;
   logic [LEN_W-1:0] len;
   logic [SW_N-1:0]  bank;
   logic kick, now_hit, run_rise, fire, active, done, reload;
   logic exp_start, now_start;

   assign exp_start = fire && !active;
   assign now_start = now_hit && !active && !fire;
   assign reload    = kick | run_rise | done;

   keyed_wdt_regs #(.LEN_W(LEN_W), .SW_N(SW_N)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .exp_start(exp_start), .now_start(now_start),
      .pulse_done(done), .mode(mode), .len(len), .bank(bank),
      .kick(kick), .now_hit(now_hit), .run_rise(run_rise)
   );

   keyed_wdt_count #(.LEN_W(LEN_W), .UNIT_LOG2(UNIT_LOG2)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(mode.run),
      .two_phase(mode.dual & mode.irq_en), .hold(active), .reload(reload),
      .len(len), .irq(irq), .fire(fire)
   );

   keyed_wdt_pulse #(.PULSE_TICKS(PULSE_TICKS), .SW_N(SW_N)) u_pulse (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(fire | now_hit),
      .pin_en(mode.pin_en), .pol_hi(mode.pol_hi), .route(mode.route),
      .bank(bank), .active(active), .done(done), .pin(ext_rst_pin), .lines(sw_rst)
   );

   assign sys_rst = active;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
   import keyed_wdt_pkg::*;
#(
   parameter int SW_N = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr,
   input logic [7:0]      addr,
   input logic [31:0]     wdata,
   input logic            irq,
   input logic            sys_rst,
   input logic            pin,
   input mode_t           mode,
   input logic [SW_N-1:0] bank,
   input logic            now_hit
);
   AST_BAD_MODE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFS_MODE && wdata[31:24] != KEY_MODE && !sys_rst) |=> $stable(mode)); // R2
   AST_RST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(mode.run || now_hit)); // R4
   AST_KICK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFS_KICK && wdata == KICK_CODE) |=> !irq); // R5
   AST_IRQ_NEEDS_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mode.run && mode.dual && mode.irq_en)); // R6
   AST_PULSE_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst) |-> !irq); // R9
   AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_rst |-> (pin == !mode.pol_hi)); // R9
   AST_BANK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFS_BANK && wdata[31:24] != KEY_BANK) |=> $stable(bank)); // R10
endmodule

bind keyed_wdt keyed_wdt_chk #(.SW_N(SW_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
   .irq(irq), .sys_rst(sys_rst), .pin(ext_rst_pin), .mode(mode), .bank(bank),
   .now_hit(now_hit)
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
   localparam int SW_N = 8;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq, sys_rst, ext_rst_pin;
   logic [SW_N-1:0] sw_rst;

   keyed_wdt #(.UNIT_LOG2(2), .PULSE_TICKS(3), .SW_N(SW_N)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sys_rst(sys_rst),
      .ext_rst_pin(ext_rst_pin), .sw_rst(sw_rst)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          sig;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t q[$];
   int compared = 0, mism = 0;
   bit finished = 0;

   function automatic logic [31:0] pick(input int s);
      case (s)
         0: return {31'b0, sys_rst};
         1: return {31'b0, irq};
         2: return {31'b0, ext_rst_pin};
         3: return {{(32-SW_N){1'b0}}, sw_rst};
         default: return bus_rdata;
      endcase
   endfunction

   always @(negedge clk) begin
      #1;
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it = q.pop_front();
         got = pick(it.sig);
         compared++;
         if (got !== it.exp) begin
            mism++;
            $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
         end
      end
   end

   task automatic want(input int s, input logic [31:0] e, input string tag);
      item_t it;
      it.sig = s; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic put(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, input logic [31:0] e, input string tag);
      bus_addr = a;
      want(4, e, tag);
      @(negedge clk);
   endtask

   task automatic go(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         compared++;
         mism++;
         $display("FAIL watchdog: got hang expected finish");
         report();
         $finish;
      end
   end

   initial begin
      int e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      want(0, 0, "R1 sys_rst idle");
      want(1, 0, "R1 irq idle");
      want(2, 1, "R1 pin inactive high");
      want(3, 0, "R1 sw_rst idle");
      peek(8'h00, 0, "R1 mode reads zero");
      peek(8'h04, 0, "R1 length reads zero");

      // R3 length key
      put(8'h04, 32'h47);
      peek(8'h04, 0, "R3 bad length key ignored");
      put(8'h04, 32'h48);
      peek(8'h04, 32'h40, "R3 length reads back without key");

      // R2 mode key
      put(8'h00, 32'h2100_0001);
      peek(8'h00, 0, "R2 bad mode key ignored");
      e = cyc; go(e + 12);
      want(0, 0, "R2 no countdown after bad key");

      // R4 single-phase timing, R9 pin high polarity, R11 cause
      put(8'h00, 32'h2200_0007); e = cyc;
      peek(8'h00, 32'h7, "R2 mode fields read back");
      go(e + 7); want(0, 0, "R4 no reset before expiry"); want(2, 0, "R9 pin idle low");
      go(e + 8); want(0, 1, "R4 reset at expiry"); want(2, 1, "R9 pin driven high");
      go(e + 10); want(0, 1, "R9 pulse still held");
      go(e + 11); want(0, 0, "R9 pulse ended");
      peek(8'h00, 32'h8006, "R11 cause set and R9 run cleared");

      // R5 wrong restart code
      put(8'h00, 32'h2200_0001); e = cyc;
      go(e + 2); put(8'h08, 32'h1970);
      go(e + 7); want(0, 0, "R5 before expiry");
      go(e + 8); want(0, 1, "R5 wrong code no reload"); want(2, 1, "R9 pin disabled stays inactive");
      go(e + 12);
      // R5 good restart
      put(8'h00, 32'h2200_0001); e = cyc;
      go(e + 4); put(8'h08, 32'h1971);
      go(e + 8); want(0, 0, "R5 restart postponed reset");
      go(e + 12); want(0, 0, "R5 not yet");
      go(e + 13); want(0, 1, "R5 reset after reload");
      go(e + 17);

      // R6 two-phase
      put(8'h00, 32'h2200_004D); e = cyc;
      go(e + 7); want(1, 0, "R6 irq before first expiry");
      go(e + 8); want(1, 1, "R6 irq at first expiry"); want(0, 0, "R6 no reset at first expiry");
      go(e + 15); want(0, 0, "R6 no reset before second expiry"); want(1, 1, "R6 irq held");
      go(e + 16); want(0, 1, "R6 reset at second expiry"); want(2, 0, "R9 pin driven low");
      go(e + 19); want(0, 0, "R9 pulse over"); want(1, 0, "R9 irq cleared at pulse end");

      // R5 restart clears irq, R7 disable
      put(8'h00, 32'h2200_0049); e = cyc;
      go(e + 8); want(1, 1, "R6 irq raised");
      put(8'h08, 32'h1971);
      want(1, 0, "R5 restart clears irq");
      go(e + 16); want(1, 0, "R6 irq waits full length");
      go(e + 17); want(1, 1, "R6 irq again"); want(0, 0, "R6 still no reset");
      put(8'h00, 32'h2200_0000);
      go(e + 19); want(1, 0, "R7 disable clears irq");
      go(e + 40); want(0, 0, "R7 no reset once disabled");

      // R6 two-phase without interrupt enable
      put(8'h00, 32'h2200_0041); e = cyc;
      go(e + 8); want(0, 1, "R6 single-phase without irq enable"); want(1, 0, "R6 no irq");
      go(e + 12);

      // R7 disable before expiry
      put(8'h00, 32'h2200_0001); e = cyc;
      go(e + 3); put(8'h00, 32'h2200_0000);
      go(e + 20); want(0, 0, "R7 stopped counter");

      // R8 immediate reset, R11 cause cleared
      put(8'h14, 32'h1208);
      want(0, 0, "R8 wrong code ignored");
      put(8'h14, 32'h1209); e = cyc;
      want(0, 1, "R8 immediate reset");
      go(e + 3); want(0, 0, "R8 pulse length");
      peek(8'h00, 0, "R11 cause cleared by command");

      // R10 reset bank
      put(8'h18, 32'h8800_00A5);
      want(3, 32'hA5, "R10 bank set");
      peek(8'h18, 32'hA5, "R10 bank reads back");
      put(8'h18, 32'h8700_00FF);
      want(3, 32'hA5, "R10 bad key ignored");
      put(8'h18, 32'h8800_0001);
      want(3, 32'h01, "R10 bank rewritten");

      // R13 route
      put(8'h00, 32'h2200_0101); e = cyc;
      go(e + 8); want(3, 32'hFF, "R13 all lines during pulse");
      go(e + 11); want(3, 32'h01, "R13 lines restored");

      // R12 auto-restart
      put(8'h00, 32'h2200_0011); e = cyc;
      go(e + 8); want(0, 1, "R12 first pulse");
      go(e + 11); want(0, 0, "R12 first pulse over");
      peek(8'h00, 32'h8011, "R12 run kept");
      go(e + 18); want(0, 0, "R12 before second expiry");
      go(e + 19); want(0, 1, "R12 second pulse");
      put(8'h00, 32'h2200_0000);
      go(e + 40); want(0, 0, "R12 stopped after disable");

      // R14 tick gating
      tick = 1'b0;
      put(8'h00, 32'h2200_0001); e = cyc;
      go(e + 20); want(0, 0, "R14 no count without tick");
      tick = 1'b1;
      go(e + 27); want(0, 0, "R14 count resumed");
      go(e + 28); want(0, 1, "R14 expiry after ticks");
      go(e + 32);

      @(negedge clk); #2;
      finished = 1;
      report();
      $finish;
   end
endmodule